// File: doc/BRIEF.md
# Associative Translation Buffer with Access-Rights Check

This block holds recently used page table entries and translates the virtual page number of each memory reference into a physical frame number. All stored entries are searched in parallel. The result returns in the same cycle as the request: a hit with the physical address, a fault, or a request to the page walker. The translated address is the frame number joined to the unchanged page offset. An entry whose tag matches can still fault: its page-table valid bit may be clear, or its access rights may forbid the requested access. A design needs one instance for instruction fetch and a separate instance for data.

Refills come back from the walker on a separate port. Ordinary refills go to an entry picked by a use-bit scheme. The lowest entries are kept for the system: software writes them by slot number, replacement never picks them, and a flush leaves them in place. A flush empties every other entry in one cycle.

Top module: `xlate_tlb`

## Requirements
- R1: With `lk_req` high, a present entry whose tag equals `lk_vaddr[31:12]`, whose page-valid bit is set and whose rights allow the access gives `lk_hit`=1, `lk_paddr`={stored frame, `lk_vaddr[11:0]`} and `lk_dirty`=stored dirty bit, in the same cycle.
- R2: With `lk_req` high and no present entry matching the tag, `walk_req`=1, `walk_vpn`=`lk_vaddr[31:12]`, and `lk_hit`, both fault flags and `lk_paddr` are 0.
- R3: A tag match on an entry whose page-valid bit is clear gives `lk_fault_inv`=1 with `lk_hit`=0, `lk_fault_prot`=0 and `walk_req`=0.
- R4: Rights bits are bit 0 read, bit 1 write and bit 2 execute. `lk_acc` is 0 for read, 1 for write, 2 for fetch, and 3 is checked as a read. A matching valid entry that lacks the needed bit gives `lk_fault_prot`=1 and `lk_hit`=0.
- R5: With `lk_req` low, every lookup output (`lk_hit`, faults, `walk_req`, `lk_paddr`, `walk_vpn`, `lk_dirty`) is 0.
- R6: A refill with `rf_sys`=0 writes the lowest-numbered unreserved entry whose use bit is clear. The new translation is visible from the next cycle.
- R7: A hit on an unreserved entry sets its use bit, and so does a refill into it. When an update would leave every unreserved use bit set, all of them clear in that same update.
- R8: Entries 0 to 3 are reserved. A refill with `rf_sys`=1 writes entry `rf_slot`. Reserved entries are never chosen for replacement and survive a flush.
- R9: `flush` empties every unreserved entry and clears all use bits in one cycle. An unreserved refill in the same cycle is dropped, and a reserved refill in the same cycle still takes effect.
- R10: After reset every entry is empty and every use bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_hit | output | 1 | Translation found and allowed |
| lk_paddr | output | 32 | Physical address on a hit, otherwise 0 |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_fault_inv | output | 1 | Tag matched an entry whose page-valid bit is clear |
| lk_fault_prot | output | 1 | Tag matched but the access rights forbid the access |
| walk_req | output | 1 | Miss: request to the page walker |
| walk_vpn | output | 20 | Page number to walk |
| rf_valid | input | 1 | Refill strobe |
| rf_sys | input | 1 | Refill targets a reserved slot |
| rf_slot | input | 2 | Reserved slot index |
| rf_vpn | input | 20 | Refill tag |
| rf_pfn | input | 20 | Refill frame number |
| rf_pv | input | 1 | Refill page-valid bit |
| rf_dirty | input | 1 | Refill dirty bit |
| rf_perm | input | 3 | Refill rights (read, write, execute) |
| flush | input | 1 | Empty all unreserved entries |

## Verification
The bench fills more unreserved entries than exist, so the use bits wrap. It then checks which translation was evicted. A design that cleared the use bits one refill late, or that let a reserved slot be chosen, would hit where a miss is due. Hits placed between refills move the victim. A victim picker that ignored use bits would evict a recently hit page. The bench also probes a tag match with a clear page-valid bit, each access kind against restricted rights, and a flush in the same cycle as both kinds of refill. A design that let a matching entry report a miss, granted fetch from read/write rights, or let a dropped refill land would fail these checks.

// File: rtl/tlb_pkg.sv
// Package: shared encodings for the translation buffer.
// Assumes rights are three bits (read, write, execute) in that bit order.
package tlb_pkg;
    localparam int PERM_W = 3;
    localparam int PERM_R = 0;
    localparam int PERM_W_BIT = 1;
    localparam int PERM_X = 2;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    // Decide whether the rights bits allow the given access kind.
    function automatic logic perm_ok(logic [PERM_W-1:0] perm, acc_e acc);
        case (acc)
            ACC_WR:  return perm[PERM_W_BIT];
            ACC_EX:  return perm[PERM_X];
            default: return perm[PERM_R];
        endcase
    endfunction
endpackage

// File: rtl/tlb_store.sv
// Module: entry storage. Each entry holds presence, tag, frame, page-valid,
// dirty and rights. One write per cycle. Flush empties entries at or above
// LOCKED. A write on the same cycle as a flush wins for its own entry.
// Assumes the caller never requests an unreserved write during a flush.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int LOCKED  = 4,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [VPN_W-1:0]                  wr_vpn,
    input  logic [PFN_W-1:0]                  wr_pfn,
    input  logic                              wr_pv,
    input  logic                              wr_dirty,
    input  logic [PERM_W-1:0]                 wr_perm,
    input  logic                              flush,
    output logic [ENTRIES-1:0]                occ,
    output logic [ENTRIES-1:0][VPN_W-1:0]     tag,
    output logic [ENTRIES-1:0][PFN_W-1:0]     pfn,
    output logic [ENTRIES-1:0]                pv,
    output logic [ENTRIES-1:0]                dirty,
    output logic [ENTRIES-1:0][PERM_W-1:0]    perm
);
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(gi));

        if (gi < LOCKED) begin : g_rsv
            // Reserved entry: written by slot number only, never flushed.
            always_ff @(posedge clk) begin
                if (!rst_n)   occ[gi] <= 1'b0;
                else if (sel) occ[gi] <= 1'b1;
            end
        end else begin : g_gen
            // Unreserved entry: filled by replacement, emptied by flush.
            always_ff @(posedge clk) begin
                if (!rst_n)     occ[gi] <= 1'b0;
                else if (sel)   occ[gi] <= 1'b1;
                else if (flush) occ[gi] <= 1'b0;
            end
        end

        // Payload fields, loaded on a write to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag[gi]   <= '0;
                pfn[gi]   <= '0;
                pv[gi]    <= 1'b0;
                dirty[gi] <= 1'b0;
                perm[gi]  <= '0;
            end else if (sel) begin
                tag[gi]   <= wr_vpn;
                pfn[gi]   <= wr_pfn;
                pv[gi]    <= wr_pv;
                dirty[gi] <= wr_dirty;
                perm[gi]  <= wr_perm;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
// Module: parallel tag compare over all entries. If more than one entry
// matches, the lowest-numbered match is used. Assumes refills are issued only
// after misses, so duplicate tags do not occur in normal use. Purely
// combinational.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0]                  vpn,
    input  logic [ENTRIES-1:0]                occ,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     tag,
    input  logic [ENTRIES-1:0][PFN_W-1:0]     pfn,
    input  logic [ENTRIES-1:0]                pv,
    input  logic [ENTRIES-1:0]                dirty,
    input  logic [ENTRIES-1:0][PERM_W-1:0]    perm,
    output logic                              any,
    output logic [IDX_W-1:0]                  sel_idx,
    output logic [PFN_W-1:0]                  sel_pfn,
    output logic                              sel_pv,
    output logic                              sel_dirty,
    output logic [PERM_W-1:0]                 sel_perm
);
    logic [ENTRIES-1:0] mvec;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign mvec[gi] = occ[gi] && (tag[gi] == vpn);
    end

    assign any = |mvec;

    // Pick the lowest matching entry and route its fields out.
    always_comb begin
        sel_idx   = '0;
        sel_pfn   = '0;
        sel_pv    = 1'b0;
        sel_dirty = 1'b0;
        sel_perm  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (mvec[i]) begin
                sel_idx   = IDX_W'(i);
                sel_pfn   = pfn[i];
                sel_pv    = pv[i];
                sel_dirty = dirty[i];
                sel_perm  = perm[i];
            end
        end
    end
endmodule

// File: rtl/tlb_repl.sv
// Module: use-bit replacement over the unreserved entries. The victim is the
// lowest unreserved entry whose use bit is clear. When an update would leave
// every unreserved bit set, all of them clear. Flush clears all bits.
// Assumes ENTRIES > LOCKED.
module tlb_repl #(
    parameter int ENTRIES = 32,
    parameter int LOCKED  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               flush,
    output logic [IDX_W-1:0]   victim,
    output logic [ENTRIES-1:0] use_q
);
    logic [ENTRIES-1:0] set_mask;
    logic [ENTRIES-1:0] use_n;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_mask
        if (gi < LOCKED) begin : g_rsv
            assign set_mask[gi] = 1'b0;
        end else begin : g_gen
            assign set_mask[gi] = (touch_en && touch_idx == IDX_W'(gi))
                               || (fill_en && fill_idx == IDX_W'(gi));
        end
    end

    // Next use vector: merge marks, then flush or wrap to all-clear.
    always_comb begin
        use_n = use_q | set_mask;
        if (flush || (&use_n[ENTRIES-1:LOCKED])) use_n = '0;
    end

    // Use-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) use_q <= '0;
        else        use_q <= use_n;
    end

    // Lowest unreserved entry with its use bit clear.
    always_comb begin
        victim = IDX_W'(LOCKED);
        for (int i = ENTRIES - 1; i >= LOCKED; i--) begin
            if (!use_q[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlate_tlb.sv
// Module: fully associative translation buffer with access-rights check.
// A lookup resolves in the same cycle. A refill or flush takes effect at the
// next clock edge. Reserved entries 0..LOCKED-1 are loaded by slot number.
// Assumes LOCKED is a power of two >= 2 and ENTRIES > LOCKED.
module xlate_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int LOCKED  = 4,
    parameter int VA_W    = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int OFF_W  = VA_W - VPN_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SLOT_W = $clog2(LOCKED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_dirty,
    output logic              lk_fault_inv,
    output logic              lk_fault_prot,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    input  logic              rf_valid,
    input  logic              rf_sys,
    input  logic [SLOT_W-1:0] rf_slot,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              rf_pv,
    input  logic              rf_dirty,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              flush
);
    logic [ENTRIES-1:0]               occ_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]    tag_vec;
    logic [ENTRIES-1:0][PFN_W-1:0]    pfn_vec;
    logic [ENTRIES-1:0]               pv_vec;
    logic [ENTRIES-1:0]               dirty_vec;
    logic [ENTRIES-1:0][PERM_W-1:0]   perm_vec;
    logic [ENTRIES-1:0]               use_vec;

    logic [VPN_W-1:0]  vpn;
    logic [OFF_W-1:0]  off;
    logic              any;
    logic [IDX_W-1:0]  sel_idx;
    logic [PFN_W-1:0]  sel_pfn;
    logic              sel_pv;
    logic              sel_dirty;
    logic [PERM_W-1:0] sel_perm;
    logic              rights_ok;
    logic [IDX_W-1:0]  victim;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              fill_en;

    assign vpn = lk_vaddr[VA_W-1:OFF_W];
    assign off = lk_vaddr[OFF_W-1:0];

    tlb_store #(.ENTRIES(ENTRIES), .LOCKED(LOCKED), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(rf_vpn), .wr_pfn(rf_pfn),
        .wr_pv(rf_pv), .wr_dirty(rf_dirty), .wr_perm(rf_perm), .flush(flush),
        .occ(occ_vec), .tag(tag_vec), .pfn(pfn_vec), .pv(pv_vec),
        .dirty(dirty_vec), .perm(perm_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_match (
        .vpn(vpn), .occ(occ_vec), .tag(tag_vec), .pfn(pfn_vec), .pv(pv_vec),
        .dirty(dirty_vec), .perm(perm_vec),
        .any(any), .sel_idx(sel_idx), .sel_pfn(sel_pfn), .sel_pv(sel_pv),
        .sel_dirty(sel_dirty), .sel_perm(sel_perm)
    );

    tlb_repl #(.ENTRIES(ENTRIES), .LOCKED(LOCKED)) u_repl (
        .clk(clk), .rst_n(rst_n),
        .touch_en(lk_hit), .touch_idx(sel_idx),
        .fill_en(fill_en), .fill_idx(victim), .flush(flush),
        .victim(victim), .use_q(use_vec)
    );

    // Refill steering: reserved slots by number, others to the victim.
    always_comb begin
        fill_en = rf_valid && !rf_sys && !flush;
        wr_en   = (rf_valid && rf_sys) || fill_en;
        wr_idx  = rf_sys ? IDX_W'(rf_slot) : victim;
    end

    assign rights_ok = perm_ok(sel_perm, acc_e'(lk_acc));

    // Lookup outcome: hit, page-valid fault, rights fault or walk request.
    always_comb begin
        lk_hit        = lk_req && any && sel_pv && rights_ok;
        lk_fault_inv  = lk_req && any && !sel_pv;
        lk_fault_prot = lk_req && any && sel_pv && !rights_ok;
        walk_req      = lk_req && !any;
        walk_vpn      = walk_req ? vpn : '0;
        lk_paddr      = lk_hit ? {sel_pfn, off} : '0;
        lk_dirty      = lk_hit && sel_dirty;
    end
endmodule

// File: rtl/xlate_tlb_chk.sv
// Module: property checker bound into xlate_tlb. Observes ports and the
// occupancy and use vectors; drives nothing.
module xlate_tlb_chk #(
    parameter int ENTRIES = 32,
    parameter int LOCKED  = 4,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_hit,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               lk_fault_inv,
    input logic               lk_fault_prot,
    input logic               walk_req,
    input logic               flush,
    input logic               rf_valid,
    input logic [ENTRIES-1:0] occ_vec,
    input logic [ENTRIES-1:0] use_vec
);
    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    // R3
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_fault_inv, lk_fault_prot, walk_req}));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_fault_inv || lk_fault_prot || walk_req));

    // R7
    use_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&use_vec[ENTRIES-1:LOCKED]));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_vec[ENTRIES-1:LOCKED] == '0) && (use_vec == '0));

    // R8
    rsv_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !rf_valid) |=> $stable(occ_vec[LOCKED-1:0]));
endmodule

bind xlate_tlb xlate_tlb_chk #(
    .ENTRIES(ENTRIES), .LOCKED(LOCKED), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault_inv(lk_fault_inv),
    .lk_fault_prot(lk_fault_prot), .walk_req(walk_req), .flush(flush),
    .rf_valid(rf_valid), .occ_vec(occ_vec), .use_vec(use_vec)
);

// File: tb/tb_xlate_tlb.sv
// Bench: behavioural reference model of the buffer, compared every cycle.
module tb_xlate_tlb;
    localparam int N = 32;
    localparam int RSV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_dirty, lk_fault_inv, lk_fault_prot, walk_req;
    logic [31:0] lk_paddr;
    logic [19:0] walk_vpn;
    logic        rf_valid = 1'b0, rf_sys = 1'b0, rf_pv = 1'b0, rf_dirty = 1'b0;
    logic [1:0]  rf_slot = '0;
    logic [19:0] rf_vpn = '0, rf_pfn = '0;
    logic [2:0]  rf_perm = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    bit       m_occ [N];
    int       m_tag [N];
    int       m_pfn [N];
    bit       m_pv  [N];
    bit       m_dty [N];
    bit [2:0] m_perm[N];
    bit       m_use [N];

    always #5 clk = ~clk;

    xlate_tlb dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
        .lk_fault_inv(lk_fault_inv), .lk_fault_prot(lk_fault_prot),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .rf_valid(rf_valid), .rf_sys(rf_sys), .rf_slot(rf_slot), .rf_vpn(rf_vpn),
        .rf_pfn(rf_pfn), .rf_pv(rf_pv), .rf_dirty(rf_dirty), .rf_perm(rf_perm),
        .flush(flush)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One cycle: compare outputs with the model, advance model, clock, idle inputs.
    task automatic cyc(input string tag);
        int mi, vic;
        bit ok, e_hit, e_inv, e_prot, e_walk, e_dty, all;
        logic [31:0] e_pa;
        logic [19:0] e_wv;
        #1;
        mi = -1;
        for (int i = 0; i < N; i++)
            if (mi < 0 && m_occ[i] && m_tag[i] == int'(lk_vaddr[31:12])) mi = i;
        ok = 0;
        if (mi >= 0) ok = (lk_acc == 2'd1) ? m_perm[mi][1] :
                          (lk_acc == 2'd2) ? m_perm[mi][2] : m_perm[mi][0];
        e_hit  = lk_req && mi >= 0 && m_pv[mi] && ok;
        e_inv  = lk_req && mi >= 0 && !m_pv[mi];
        e_prot = lk_req && mi >= 0 && m_pv[mi] && !ok;
        e_walk = lk_req && mi < 0;
        e_pa   = e_hit ? {m_pfn[mi][19:0], lk_vaddr[11:0]} : 32'd0;
        e_dty  = e_hit && m_dty[mi];
        e_wv   = e_walk ? lk_vaddr[31:12] : 20'd0;
        checks++;
        if ({lk_hit, lk_fault_inv, lk_fault_prot, walk_req, lk_dirty, lk_paddr, walk_vpn} !==
            {e_hit, e_inv, e_prot, e_walk, e_dty, e_pa, e_wv}) begin
            fails++;
            $display("FAIL %s: got hit=%b inv=%b prot=%b walk=%b dty=%b pa=%h wv=%h exp hit=%b inv=%b prot=%b walk=%b dty=%b pa=%h wv=%h",
                     tag, lk_hit, lk_fault_inv, lk_fault_prot, walk_req, lk_dirty, lk_paddr, walk_vpn,
                     e_hit, e_inv, e_prot, e_walk, e_dty, e_pa, e_wv);
        end
        // Model next state
        vic = RSV;
        for (int i = N - 1; i >= RSV; i--) if (!m_use[i]) vic = i;
        if (e_hit && mi >= RSV) m_use[mi] = 1;
        if (flush) begin
            for (int i = RSV; i < N; i++) begin m_occ[i] = 0; m_use[i] = 0; end
        end
        if (rf_valid && (rf_sys || !flush)) begin
            int w;
            w = rf_sys ? int'(rf_slot) : vic;
            m_occ[w] = 1; m_tag[w] = int'(rf_vpn); m_pfn[w] = int'(rf_pfn);
            m_pv[w] = rf_pv; m_dty[w] = rf_dirty; m_perm[w] = rf_perm;
            if (!rf_sys) m_use[w] = 1;
        end
        all = 1;
        for (int i = RSV; i < N; i++) all &= m_use[i];
        if (all) for (int i = RSV; i < N; i++) m_use[i] = 0;
        @(posedge clk);
        @(negedge clk);
        lk_req = 0; rf_valid = 0; rf_sys = 0; flush = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc, input string tag);
        lk_req = 1; lk_vaddr = va; lk_acc = acc;
        cyc(tag);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit pv,
                        input bit dty, input logic [2:0] perm, input string tag);
        rf_valid = 1; rf_sys = 0; rf_vpn = vpn; rf_pfn = pfn; rf_pv = pv;
        rf_dirty = dty; rf_perm = perm;
        cyc(tag);
    endtask

    task automatic sfill(input logic [1:0] slot, input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [2:0] perm, input string tag);
        rf_valid = 1; rf_sys = 1; rf_slot = slot; rf_vpn = vpn; rf_pfn = pfn;
        rf_pv = 1; rf_dirty = 0; rf_perm = perm;
        cyc(tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_occ[i] = 0; m_use[i] = 0; m_tag[i] = 0; m_pfn[i] = 0;
            m_pv[i] = 0; m_dty[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: empty after reset; R2 miss path
        look(32'h1234_5678, 2'd0, "R10 reset empty");
        look(32'h0001_0000, 2'd2, "R2 miss");
        cyc("R5 idle");
        // R8: reserved slots
        sfill(2'd0, 20'h00010, 20'h80010, 3'b111, "R8 load slot0");
        sfill(2'd3, 20'h00020, 20'h80020, 3'b001, "R8 load slot3");
        look(32'h0001_0ABC, 2'd2, "R8 slot0 fetch hit");
        look(32'h0002_0004, 2'd1, "R4 slot3 write denied");
        look(32'h0002_0008, 2'd3, "R4 code3 as read");
        // R1 / R4 / R6
        fill(20'h12345, 20'h54321, 1, 1, 3'b011, "R6 refill");
        look(32'h1234_5ABC, 2'd0, "R1 read hit");
        look(32'h1234_5FFF, 2'd1, "R1 write hit");
        look(32'h1234_5000, 2'd2, "R4 fetch denied");
        // R3
        fill(20'h40000, 20'h00001, 0, 0, 3'b111, "R6 refill invalid pte");
        look(32'h4000_0010, 2'd0, "R3 invalid pte");
        look(32'h4000_0010, 2'd1, "R3 invalid pte write");
        cyc("R5 idle after faults");
        // R7: overfill unreserved entries, touching some in between
        for (int k = 0; k < 30; k++) begin
            fill(20'h01000 + 20'(k), 20'h20000 + 20'(k), 1, k[0], 3'b101, "R7 overfill");
            if (k % 7 == 3) look({20'h12345, 12'h010}, 2'd0, "R7 touch");
        end
        for (int k = 0; k < 30; k++)
            look({20'h01000 + 20'(k), 12'h044}, 2'd2, "R7 after wrap");
        look(32'h1234_5010, 2'd0, "R7 touched entry");
        look(32'h4000_0010, 2'd0, "R7 evicted entry");
        for (int k = 0; k < 6; k++) begin
            look({20'h01000 + 20'(k * 3), 12'h0}, 2'd0, "R7 hit marks");
            fill(20'h0A000 + 20'(k), 20'h30000 + 20'(k), 1, 0, 3'b111, "R6 victim after hits");
        end
        for (int k = 0; k < 18; k++)
            look({20'h01000 + 20'(k), 12'h0}, 2'd0, "R7 survivors");
        for (int k = 0; k < 6; k++)
            look({20'h0A000 + 20'(k), 12'h0}, 2'd1, "R6 new entries");
        // R9: flush
        flush = 1;
        cyc("R9 flush");
        look(32'h0A00_0000, 2'd0, "R9 flushed miss");
        look(32'h0100_5000, 2'd0, "R9 flushed miss 2");
        look(32'h0001_0000, 2'd0, "R8 survives flush");
        look(32'h0002_0000, 2'd0, "R8 slot3 survives flush");
        // R9: flush with unreserved refill in same cycle
        flush = 1; rf_valid = 1; rf_sys = 0; rf_vpn = 20'h0BEEF; rf_pfn = 20'h11111;
        rf_pv = 1; rf_dirty = 0; rf_perm = 3'b111;
        cyc("R9 flush+refill");
        look(32'h0BEE_F000, 2'd0, "R9 dropped refill");
        // R9/R8: flush with reserved refill in same cycle
        flush = 1; rf_valid = 1; rf_sys = 1; rf_slot = 2'd1; rf_vpn = 20'h0CAFE;
        rf_pfn = 20'h22222; rf_pv = 1; rf_dirty = 1; rf_perm = 3'b010;
        cyc("R9 flush+sys refill");
        look(32'h0CAF_E123, 2'd1, "R9 sys refill kept");
        look(32'h0CAF_E123, 2'd0, "R4 write-only read denied");
        fill(20'h0D00D, 20'h33333, 1, 0, 3'b001, "R6 refill after flush");
        look(32'h0D00_D456, 2'd0, "R6 first entry after flush");
        done = 1;
        summary();
    end
endmodule